// File: doc/BRIEF.md
# Two-Device Cascade Select

This block lets two identical memory devices sit in one host memory window with no decoding logic between them. Each device holds one copy of the block. Static strap pins give each copy its identity. The host writes a select value into a small register. The copy whose strap identity equals that value owns the shared register space. The owner drives read data and accepts ordinary register writes. The other copy keeps its data bus released and ignores those writes.

Two register addresses form a broadcast class, and every copy takes writes to them whatever the selection is. The first is the select register itself, so the host can always move ownership. The second is an output-control register, which has to hold the same value in both devices. A select value that matches neither strap leaves both devices off the bus.

Top module: `cascade_sel`

## Requirements
- R1: After reset the select value is 2'b00 and the output-control register is 0. A copy strapped 2'b00 owns the register space and a copy strapped 2'b01 does not.
- R2: `owner` is high exactly when the stored select value equals `strap_id`. Strap 2'b00 is the first device, which is also the single-device setting, and strap 2'b01 is the second device.
- R3: `data_oe` is high only in a cycle where the copy is owner, `ce_n` is low and `rd_en` is high. It is combinational in those inputs.
- R4: A write to `SEL_ADDR` with `ce_n` low loads `wdata[1:0]` into the select register on every copy, owner or not. The new ownership shows from the next clock edge on, and `wdata[7:2]` is ignored.
- R5: A write to `OUTCTL_ADDR` with `ce_n` low loads all 8 bits of `wdata` into `outctl` on every copy, owner or not, from the next edge on.
- R6: `reg_wr_accept` pulses for a write with `ce_n` low in two cases. The first is a write to a broadcast address (`SEL_ADDR`, `OUTCTL_ADDR`), and for such a write `bcast_wr` is also high. The second is a write to any other address, and only on the owning copy.
- R7: When the select value is 2'b10 or 2'b11, neither cascaded copy is owner, and neither raises `data_oe` or accepts a non-broadcast write.
- R8: With `ce_n` high, no write changes the select register or `outctl`, and `data_oe`, `reg_wr_accept` and `bcast_wr` all stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| strap_id | input | ID_W | Static device identity strap |
| ce_n | input | 1 | Host chip enable, active low |
| wr_en | input | 1 | Host write strobe |
| rd_en | input | 1 | Host read strobe |
| addr | input | ADDR_W | Host register address |
| wdata | input | 8 | Host write data |
| owner | output | 1 | This copy owns the register space |
| data_oe | output | 1 | Drive enable for the read data bus |
| reg_wr_accept | output | 1 | Register write accepted by this copy |
| bcast_wr | output | 1 | Accepted write targets a broadcast register |
| outctl | output | 8 | Output-control register value |

## Verification
The bench builds two copies with the default parameters: ID_W of 2, a 13-bit address, and the select and output-control registers at distinct addresses. The copies are strapped 2'b00 and 2'b01 on a shared bus. Because the select field is two bits wide, the values 2'b10 and 2'b11 are in reach, and the bench uses them to check that neither copy drives the bus. With two copies present, broadcast writes can be made while each copy is the non-owner, and a wrong data enable on either copy shows at the ports.

// File: rtl/cascade_sel.sv
module cascade_sel #(
  parameter int ID_W = 2,
  parameter int ADDR_W = 13,
  parameter logic [ADDR_W-1:0] SEL_ADDR = 13'h01A0,
  parameter logic [ADDR_W-1:0] OUTCTL_ADDR = 13'h01A4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ID_W-1:0]   strap_id,
  input  logic              ce_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic              owner,
  output logic              data_oe,
  output logic              reg_wr_accept,
  output logic              bcast_wr,
  output logic [7:0]        outctl
);

  logic [ID_W-1:0] sel_q;
  logic [7:0]      outctl_q;
  logic            host_wr, wr_sel, wr_outctl;

  assign host_wr   = !ce_n && wr_en;
  assign wr_sel    = host_wr && (addr == SEL_ADDR);
  assign wr_outctl = host_wr && (addr == OUTCTL_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q    <= '0;
      outctl_q <= '0;
    end else begin
      if (wr_sel)    sel_q    <= wdata[ID_W-1:0];
      if (wr_outctl) outctl_q <= wdata;
    end
  end

  assign owner         = (sel_q == strap_id);
  assign data_oe       = owner && !ce_n && rd_en;
  assign bcast_wr      = wr_sel || wr_outctl;
  assign reg_wr_accept = bcast_wr || (host_wr && owner);
  assign outctl        = outctl_q;

  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |=> (outctl == 8'h00));

  assert_sel_update_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && wr_en && addr == SEL_ADDR) |=> (owner == ($past(wdata[ID_W-1:0]) == strap_id)));

  assert_outctl_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && wr_en && addr == OUTCTL_ADDR) |=> (outctl == $past(wdata)));

  assert_nonowner_bcast_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_accept && !owner) |-> bcast_wr);

  assert_oe_needs_ce_R3: assert property (@(posedge clk) disable iff (!rst_n)
    data_oe |-> (!ce_n && rd_en));

  assert_ce_high_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |=> ($stable(outctl) && $stable(owner)));

endmodule

// File: tb/sim_cascade_sel.sv
module sim_cascade_sel;
  localparam int CLK_PERIOD = 10;
  localparam logic [12:0] SEL_A = 13'h01A0;
  localparam logic [12:0] OUT_A = 13'h01A4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b1, wr_en = 1'b0, rd_en = 1'b0;
  logic [12:0] addr = '0;
  logic [7:0] wdata = '0;
  logic own0, oe0, acc0, bc0, own1, oe1, acc1, bc1;
  logic [7:0] oc0, oc1;
  int checks = 0, errors = 0;
  logic [1:0] sel_m;
  logic [7:0] outctl_m;

  always #(CLK_PERIOD/2) clk = ~clk;

  cascade_sel u0 (.clk(clk), .rst_n(rst_n), .strap_id(2'b00), .ce_n(ce_n), .wr_en(wr_en),
    .rd_en(rd_en), .addr(addr), .wdata(wdata), .owner(own0), .data_oe(oe0),
    .reg_wr_accept(acc0), .bcast_wr(bc0), .outctl(oc0));
  cascade_sel u1 (.clk(clk), .rst_n(rst_n), .strap_id(2'b01), .ce_n(ce_n), .wr_en(wr_en),
    .rd_en(rd_en), .addr(addr), .wdata(wdata), .owner(own1), .data_oe(oe1),
    .reg_wr_accept(acc1), .bcast_wr(bc1), .outctl(oc1));

  function automatic logic f_owner(logic [1:0] sel, logic [1:0] strap);
    return sel == strap;
  endfunction
  function automatic logic f_bcast();
    return !ce_n && wr_en && (addr == SEL_A || addr == OUT_A);
  endfunction
  function automatic logic f_acc(logic [1:0] strap);
    return f_bcast() || (!ce_n && wr_en && f_owner(sel_m, strap));
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic check_all(string req);
    chk({req, " owner u0"}, own0, f_owner(sel_m, 2'b00));
    chk({req, " owner u1"}, own1, f_owner(sel_m, 2'b01));
    chk({req, " oe u0"}, oe0, f_owner(sel_m, 2'b00) && !ce_n && rd_en);
    chk({req, " oe u1"}, oe1, f_owner(sel_m, 2'b01) && !ce_n && rd_en);
    chk({req, " acc u0"}, acc0, f_acc(2'b00));
    chk({req, " acc u1"}, acc1, f_acc(2'b01));
    chk({req, " bcast u0"}, bc0, f_bcast());
    chk({req, " bcast u1"}, bc1, f_bcast());
    chk({req, " outctl u0"}, oc0, outctl_m);
    chk({req, " outctl u1"}, oc1, outctl_m);
  endtask

  task automatic cyc(string req, logic c, logic w, logic r, logic [12:0] a, logic [7:0] d);
    @(negedge clk);
    ce_n = c; wr_en = w; rd_en = r; addr = a; wdata = d;
    #1 check_all(req);
    @(posedge clk);
    if (!c && w && a == SEL_A) sel_m = d[1:0];
    if (!c && w && a == OUT_A) outctl_m = d;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [12:0] ra;
    int op;
    void'($urandom(32'd4242));
    sel_m = 2'b00; outctl_m = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset owner u0", own0, 1'b1);
    chk("R1 reset owner u1", own1, 1'b0);
    chk("R1 reset outctl", oc0, 8'h00);
    rst_n = 1'b1;
    cyc("R1 R3 read after reset", 1'b0, 1'b0, 1'b1, 13'h0004, 8'h00);
    cyc("R4 select second", 1'b0, 1'b1, 1'b0, SEL_A, 8'hFD);
    cyc("R2 R3 second owns", 1'b0, 1'b0, 1'b1, 13'h0010, 8'h00);
    cyc("R6 owner-only write", 1'b0, 1'b1, 1'b0, 13'h0010, 8'h33);
    cyc("R4 select none", 1'b0, 1'b1, 1'b0, SEL_A, 8'h02);
    cyc("R7 no driver", 1'b0, 1'b0, 1'b1, 13'h0010, 8'h00);
    cyc("R7 no accept", 1'b0, 1'b1, 1'b0, 13'h0020, 8'h55);
    chk("R7 u0 released", oe0, 1'b0);
    chk("R7 u1 released", oe1, 1'b0);
    cyc("R5 bcast outctl", 1'b0, 1'b1, 1'b0, OUT_A, 8'hA5);
    cyc("R5 outctl seen", 1'b0, 1'b0, 1'b0, 13'h0000, 8'h00);
    cyc("R4 select 11", 1'b0, 1'b1, 1'b0, SEL_A, 8'h03);
    cyc("R7 none at 11", 1'b0, 1'b0, 1'b1, 13'h0000, 8'h00);
    cyc("R8 ce high sel", 1'b1, 1'b1, 1'b1, SEL_A, 8'h00);
    cyc("R8 ce high outctl", 1'b1, 1'b1, 1'b0, OUT_A, 8'h11);
    cyc("R8 held", 1'b0, 1'b0, 1'b1, 13'h0000, 8'h00);
    for (int i = 0; i < 400; i++) begin
      op = $urandom_range(0, 4);
      ra = (op == 0) ? SEL_A : (op == 1) ? OUT_A : 13'($urandom_range(0, 8191));
      cyc("R2 R3 R6 random", ($urandom_range(0, 3) == 0), 1'($urandom), 1'($urandom),
          ra, 8'($urandom));
    end
    cyc("R2 final", 1'b0, 1'b0, 1'b1, 13'h0000, 8'h00);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule